// File: doc/BRIEF.md
# Watchdog Timer with Register Port

This block is a watchdog timer that software reaches through a plain 32-bit register port with a write strobe, an address and combinational read data. The control register holds a tick divisor and four flag bits: run, divider enable, tick-clock enable and reset-output enable. A prescaler turns the input clock into a slower tick. For example, a divisor equal to the clock rate divided by 1000 gives one tick every millisecond. Each tick advances an up-counter toward a programmed limit.

When the count reaches the limit, the counter stops there and the block issues a single-cycle reset request, provided the reset output is enabled. Software keeps the system alive by writing any value to the kick address, which returns the count to zero. The limit and the live count are both read from one register: the limit sits in the low half and the count in the high half. Software can therefore work out the remaining time with one read.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register and the limit/count register both read 0 and rst_req_o is low.
- R2: The control register at offset 0x0 stores the divisor in bits 17:0, run in bit 18, reset-output enable in bit 21, tick-clock enable in bit 24 and divider enable in bit 25. All other bits read 0, and offset 0xC reads 0.
- R3: Writing offset 0x8 loads the limit from data bits 15:0 and ignores bits 31:16. Reading offset 0x8 returns {count[15:0], limit[15:0]}.
- R4: While run, divider enable and tick-clock enable are all 1, the count advances by one every D clocks for a divisor D ≥ 1. A divisor of 0 behaves like 1.
- R5: If either the divider enable or the tick-clock enable is 0, the count does not advance.
- R6: Once the count equals the limit, it holds that value until a kick, a disable or a limit change.
- R7: With the reset output enabled, rst_req_o is high for exactly one cycle, one clock after the count first equals the limit while running. It pulses once per arrival.
- R8: With the reset output disabled, rst_req_o stays low even when the count reaches and holds the limit.
- R9: Any write to offset 0xC, whatever the data, clears the count to 0 on that clock edge.
- R10: Clearing the run bit clears the count and the prescaler phase. While stopped, no tick occurs and no reset request is issued.
- R11: After a kick, a new limit smaller than the old count takes effect. The watchdog then expires after the new number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its default parameters: an 18-bit divisor, a 16-bit count and a 4-bit address. Small divisors (0, 1, 3 and 4) and small limits (3 to 20) bring expiry within tens of cycles. A behavioural model tracks the prescaler phase, the count and the expected reset pulse on every clock. This exposes both the one-cycle pulse timing and the limit-hold behaviour.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_CTRL  = 'h0;
  localparam int OFS_LIMIT = 'h8;
  localparam int OFS_KICK  = 'hC;

  localparam int BIT_RUN   = 18;
  localparam int BIT_RSTEN = 21;
  localparam int BIT_CLKEN = 24;
  localparam int BIT_PREEN = 25;

  localparam int HALF_W    = 16;

  typedef struct packed {
    logic pre_en;
    logic clk_en;
    logic rst_en;
    logic run;
  } wdog_flags_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output wdog_flags_t       flags_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              kick_o,
  output logic              limit_wr_o,
  output logic [31:0]       rdata_o
);
  logic sel_ctrl, sel_limit, sel_kick;
  wdog_flags_t      flags_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] limit_q;

  assign sel_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_limit = (addr_i == ADDR_W'(OFS_LIMIT));
  assign sel_kick  = (addr_i == ADDR_W'(OFS_KICK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      div_q   <= '0;
      limit_q <= '0;
    end else begin
      if (wr_i && sel_ctrl) begin
        div_q          <= wdata_i[DIV_W-1:0];
        flags_q.run    <= wdata_i[BIT_RUN];
        flags_q.rst_en <= wdata_i[BIT_RSTEN];
        flags_q.clk_en <= wdata_i[BIT_CLKEN];
        flags_q.pre_en <= wdata_i[BIT_PREEN];
      end
      // upper half of the limit register is read-only count
      if (wr_i && sel_limit) limit_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[DIV_W-1:0] = div_q;
      rdata_o[BIT_RUN]   = flags_q.run;
      rdata_o[BIT_RSTEN] = flags_q.rst_en;
      rdata_o[BIT_CLKEN] = flags_q.clk_en;
      rdata_o[BIT_PREEN] = flags_q.pre_en;
    end else if (sel_limit) begin
      rdata_o[CNT_W-1:0]       = limit_q;
      rdata_o[HALF_W +: CNT_W] = count_i;
    end
  end

  assign flags_o    = flags_q;
  assign div_o      = div_q;
  assign limit_o    = limit_q;
  assign kick_o     = wr_i & sel_kick;
  assign limit_wr_o = wr_i & sel_limit;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] phase_q;
  logic             at_end;

  // divisor 0 or 1 both give a tick every clock
  assign at_end = (EXT_W'(phase_q) + EXT_W'(1)) >= EXT_W'(div_i);
  assign tick_o = en_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (!en_i)  phase_q <= '0;
    else if (at_end) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rst_en_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] count_q;
  logic             match, seen_q, req_q;

  assign match = run_i && (count_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      seen_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (!run_i || kick_i)         count_q <= '0;
      else if (tick_i && !match)    count_q <= count_q + 1'b1;
      // seen_q marks that this arrival at the limit already fired
      seen_q <= match && !kick_i;
      req_q  <= match && !seen_q && rst_en_i;
    end
  end

  assign count_o   = count_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              rst_req_o
);
  wdog_flags_t      flags;
  logic [DIV_W-1:0] div_w;
  logic [CNT_W-1:0] limit_w, count_w;
  logic             kick_w, limit_wr_w, tick_w, tick_en_w;

  wdog_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .count_i    (count_w),
    .flags_o    (flags),
    .div_o      (div_w),
    .limit_o    (limit_w),
    .kick_o     (kick_w),
    .limit_wr_o (limit_wr_w),
    .rdata_o    (reg_rdata_o)
  );

  assign tick_en_w = flags.run & flags.pre_en & flags.clk_en;

  wdog_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_w),
    .div_i  (div_w),
    .tick_o (tick_w)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (flags.run),
    .rst_en_i  (flags.rst_en),
    .tick_i    (tick_w),
    .kick_i    (kick_w),
    .limit_i   (limit_w),
    .count_o   (count_w),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdog_timer_sva.sv
module wdog_timer_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             pre_en_i,
  input logic             clk_en_i,
  input logic             rst_en_i,
  input logic             tick_i,
  input logic             kick_i,
  input logic             limit_wr_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] limit_i,
  input logic             rst_req_i
);
  a_r7_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);

  a_r10_req_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(run_i));

  a_r8_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(rst_en_i));

  a_r9_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (count_i == '0));

  a_r5_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (run_i && pre_en_i && clk_en_i));

  a_r6_hold_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !kick_i && !limit_wr_i && count_i == limit_i) |=> $stable(count_i));

  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !kick_i) |=> (count_i == $past(count_i) || count_i == CNT_W'($past(count_i) + 1'b1)));
endmodule

bind wdog_timer wdog_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (flags.run),
  .pre_en_i   (flags.pre_en),
  .clk_en_i   (flags.clk_en),
  .rst_en_i   (flags.rst_en),
  .tick_i     (tick_w),
  .kick_i     (kick_w),
  .limit_wr_i (limit_wr_w),
  .count_i    (count_w),
  .limit_i    (limit_w),
  .rst_req_i  (rst_req_o)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;

  int checks = 0, failures = 0, pulses = 0;
  logic [31:0] rd_val;

  // behavioural reference state
  logic [31:0] m_ctrl = '0;
  int m_lim = 0, m_cnt = 0, m_phase = 0;
  bit m_seen = 0, m_req = 0;

  always #10 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_req_o(req)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_lim = 0; m_cnt = 0; m_phase = 0; m_seen = 0; m_req = 0;
    end else begin
      bit run, active, tick, kick, hit;
      int dv;
      run    = m_ctrl[18];
      active = run && m_ctrl[25] && m_ctrl[24];
      dv     = int'(m_ctrl[17:0]);
      tick   = active && (m_phase + 1 >= dv);
      kick   = wr && addr == 4'hC;
      hit    = run && (m_cnt == m_lim);
      m_req  = hit && !m_seen && m_ctrl[21];
      m_seen = hit && !kick;
      m_phase = (!active || tick) ? 0 : m_phase + 1;
      if (!run || kick) m_cnt = 0;
      else if (tick && !hit) m_cnt = (m_cnt + 1) % 65536;
      if (wr && addr == 4'h0) m_ctrl = wdata & 32'h0327FFFF;
      if (wr && addr == 4'h8) m_lim = int'(wdata[15:0]);
    end
  end

  // per-cycle comparison of the reset request (R7, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (req !== m_req) begin
        failures++;
        $display("FAIL R7 cycle rst_req actual=%0b expected=%0b at %0t", req, m_req, $time);
      end
      if (req) pulses++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a);
    addr = a;
    #1;
    rd_val = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int p0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    rd_reg(4'h0); chk("R1 ctrl reset", rd_val, 32'h0);
    rd_reg(4'h8); chk("R1 limit reset", rd_val, 32'h0);
    chk("R1 rst_req reset", {31'b0, req}, 32'h0);
    // R2: run bit left clear
    wr_reg(4'h0, 32'hFFFB_FFFF);
    rd_reg(4'h0); chk("R2 ctrl mask", rd_val, 32'h0323_FFFF);
    rd_reg(4'hC); chk("R2 kick reads 0", rd_val, 32'h0);
    wr_reg(4'h0, 32'h0);
    // R3: upper half ignored
    wr_reg(4'h8, 32'hABCD_000A);
    rd_reg(4'h8); chk("R3 limit readback", rd_val, 32'h0000_000A);
    // R7, R6: run with divisor 4
    wr_reg(4'h0, 32'h0324_0004);
    rd_reg(4'h0); chk("R2 ctrl run", rd_val, 32'h0324_0004);
    idle(12);
    rd_reg(4'h8); chk("R4 count div4", {16'h0, rd_val[31:16]}, m_cnt);
    idle(48);
    chk("R7 one pulse", pulses, 1);
    rd_reg(4'h8); chk("R6 hold at limit", rd_val, 32'h000A_000A);
    idle(20);
    chk("R7 no repeat", pulses, 1);
    // R9
    wr_reg(4'hC, 32'h1234_5678);
    rd_reg(4'h8); chk("R9 kick clears", rd_val, 32'h0000_000A);
    // R4 divisor 1 and 0
    wr_reg(4'h0, 32'h0324_0001);
    wr_reg(4'hC, 32'h0);
    idle(5);
    rd_reg(4'h8); chk("R4 div1", {16'h0, rd_val[31:16]}, 32'd5);
    wr_reg(4'h0, 32'h0324_0000);
    wr_reg(4'hC, 32'hFFFF_FFFF);
    idle(3);
    rd_reg(4'h8); chk("R4 div0", {16'h0, rd_val[31:16]}, 32'd3);
    wr_reg(4'h0, 32'h0324_0003);
    wr_reg(4'hC, 32'h0);
    idle(9);
    rd_reg(4'h8); chk("R4 div3", {16'h0, rd_val[31:16]}, m_cnt);
    // R5
    wr_reg(4'h0, 32'h0124_0001);
    wr_reg(4'hC, 32'h0);
    idle(20);
    rd_reg(4'h8); chk("R5 divider off", {16'h0, rd_val[31:16]}, 32'd0);
    wr_reg(4'h0, 32'h0224_0001);
    wr_reg(4'hC, 32'h0);
    idle(20);
    rd_reg(4'h8); chk("R5 tick clock off", {16'h0, rd_val[31:16]}, 32'd0);
    // R8
    p0 = pulses;
    wr_reg(4'h8, 32'h3);
    wr_reg(4'h0, 32'h0304_0001);
    wr_reg(4'hC, 32'h0);
    idle(10);
    rd_reg(4'h8); chk("R8 count held", rd_val, 32'h0003_0003);
    chk("R8 no pulse", pulses, p0);
    // R10
    wr_reg(4'h0, 32'h0320_0001);
    idle(2);
    rd_reg(4'h8); chk("R10 stop clears", rd_val, 32'h0000_0003);
    idle(20);
    rd_reg(4'h8); chk("R10 stays 0", rd_val, 32'h0000_0003);
    chk("R10 no pulse", pulses, p0);
    // R11
    wr_reg(4'h8, 32'd20);
    wr_reg(4'h0, 32'h0324_0001);
    idle(15);
    rd_reg(4'h8); chk("R11 pre-kick count", {16'h0, rd_val[31:16]}, m_cnt);
    wr_reg(4'hC, 32'h0);
    wr_reg(4'h8, 32'd5);
    idle(10);
    rd_reg(4'h8); chk("R11 new limit held", rd_val, 32'h0005_0005);
    chk("R11 new pulse", pulses, p0 + 1);
    idle(2);
    summary();
  end
endmodule